// File: doc/BRIEF.md
# Memory-Mapped Compare Timer Frame

This block is one register frame of a system timer. It holds a free-running count that advances by one on every clock where the tick enable input is high. A 32-bit register bus reads that count through two views. The physical view is the raw count. The virtual view is the raw count plus a fixed offset set at build time. Each view has a compare channel. A channel holds a 64-bit compare value and a control word. When the channel is enabled and its view's count has reached the compare value, the channel raises a status flag. It drives its interrupt line unless the mask bit is set.

Software reaches the frame through a valid/ready request and a one-cycle response. A bus state machine has two states. In BUS_IDLE it accepts a request (transition ACCEPT) and moves to BUS_RESP. In BUS_RESP it presents the response for one cycle and always returns to BUS_IDLE (transition RETIRE). Counts and compare values wider than the bus are split into a low word at the base offset and a high word four bytes above it. Every read of a count word returns the counter's value at that moment, so software reads high, low, high and retries when the two high words differ. Software is expected to disable a channel before it rewrites that channel's compare value.

Top module: `cmp_timer_frame`

## Requirements
- R1: After reset the count, both compare values and every control bit are zero, both interrupt lines are low and req_ready is high.
- R2: The count advances by exactly one on each clock edge where tick_en is high and holds otherwise. It is CNT_W (56) bits wide and wraps at 2^56. Bits 63:56 of every count view read as zero.
- R3: Byte offsets 0x00/0x04 return the low/high words of the physical count. Offsets 0x08/0x0C return the low/high words of the virtual count, which is (physical + VIRT_OFFSET) mod 2^56. Each read returns the live value at the accept edge. Writes to these offsets are ignored.
- R4: Offset 0x10 reads the FREQ_WORD parameter, and writes to it are ignored.
- R5: The physical compare value is at 0x20 (low) and 0x24 (high). The virtual compare value is at 0x30 (low) and 0x34 (high). Each half can be written and read back on its own.
- R6: The control words are at 0x2C (physical) and 0x3C (virtual). Bit 0 is enable and bit 1 is mask, and both can be read and written. Bit 2 is status and is read-only, so writes to it are ignored. Bits 31:3 read zero.
- R7: Status is 1 exactly when enable is 1 and the channel's own 64-bit zero-extended count is unsigned greater than or equal to its 64-bit compare value. This holds in both the low and the high word.
- R8: Each interrupt line equals its channel's status AND NOT mask, in the same cycle as the register change that causes it. Setting mask silences the line and leaves enable set.
- R9: req_ready is high only in BUS_IDLE. An accepted request (req_valid and req_ready) makes rsp_valid high for exactly the next cycle, with req_ready low in that cycle. rsp_rdata carries the read value sampled at the accept edge, or zero for a write.
- R10: Any other offset, and any address whose bits 1:0 are not zero, reads zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count advance enable |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Frame can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq_phys | output | 1 | Physical channel interrupt |
| irq_virt | output | 1 | Virtual channel interrupt |

## Verification
A write takes effect at its accept edge. Because status and the interrupt lines are combinational from the registers, they settle in the same cycle. rsp_valid and rsp_rdata show up one edge after acceptance and carry values taken before the count's own update at that edge. A tick seen at one edge is visible in the count from that edge onward. The bench keeps a behavioural model that it advances at every rising edge from the same inputs the design sees. It compares ready, response and interrupts at every falling edge, where all of these are settled. Directed checks read registers after a transfer has finished and compare them with hand-derived constants.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int unsigned VAL_W  = 64;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NUM_CH = 2;

    // word indices (byte offset / 4)
    localparam int unsigned W_PCNT_LO = 0;
    localparam int unsigned W_PCNT_HI = 1;
    localparam int unsigned W_VCNT_LO = 2;
    localparam int unsigned W_VCNT_HI = 3;
    localparam int unsigned W_FREQ    = 4;

    localparam int unsigned CH_BASE_PHYS  = 8;
    localparam int unsigned CH_STRIDE     = 4;
    localparam int unsigned CH_OFS_CMP_LO = 0;
    localparam int unsigned CH_OFS_CMP_HI = 1;
    localparam int unsigned CH_OFS_CTRL   = 3;

    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_MASK = 1;
    localparam int unsigned CTRL_STAT = 2;

    function automatic int unsigned ch_base(int unsigned c);
        return CH_BASE_PHYS + CH_STRIDE * c;
    endfunction

endpackage

// File: rtl/tfr_counter.sv
module tfr_counter #(
    parameter int unsigned CNT_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/tfr_channel.sv
module tfr_channel #(
    parameter int unsigned CNT_W = 56
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           count,
    input  logic                       wr_cmp_lo,
    input  logic                       wr_cmp_hi,
    input  logic                       wr_ctrl,
    input  logic [tfr_pkg::DATA_W-1:0] wdata,
    output logic [tfr_pkg::VAL_W-1:0]  cmp_val,
    output logic                       en,
    output logic                       mask,
    output logic                       status,
    output logic                       irq
);

    localparam int unsigned HALF = tfr_pkg::DATA_W;

    logic [tfr_pkg::VAL_W-1:0] cmp_q;
    logic                      en_q;
    logic                      mask_q;
    logic [tfr_pkg::VAL_W-1:0] count_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            if (wr_cmp_lo) begin
                cmp_q[HALF-1:0] <= wdata;
            end
            if (wr_cmp_hi) begin
                cmp_q[tfr_pkg::VAL_W-1:HALF] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= wdata[tfr_pkg::CTRL_EN];
            mask_q <= wdata[tfr_pkg::CTRL_MASK];
        end
    end

    assign count_ext = tfr_pkg::VAL_W'(count);

    always_comb begin
        status = en_q && (count_ext >= cmp_q);
        irq    = status && !mask_q;
    end

    assign cmp_val = cmp_q;
    assign en      = en_q;
    assign mask    = mask_q;

endmodule

// File: rtl/tfr_bus_fsm.sv
module tfr_bus_fsm (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [tfr_pkg::DATA_W-1:0] rd_word,
    output logic                       req_ready,
    output logic                       accept,
    output logic                       rsp_valid,
    output logic [tfr_pkg::DATA_W-1:0] rsp_rdata
);

    tfr_pkg::bus_state_e state_q, state_d;
    logic [tfr_pkg::DATA_W-1:0] rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= tfr_pkg::BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT (idle -> resp), RETIRE (resp -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            tfr_pkg::BUS_IDLE: if (req_valid) state_d = tfr_pkg::BUS_RESP;
            tfr_pkg::BUS_RESP: state_d = tfr_pkg::BUS_IDLE;
            default:           state_d = tfr_pkg::BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            tfr_pkg::BUS_IDLE: req_ready = 1'b1;
            tfr_pkg::BUS_RESP: rsp_valid = 1'b1;
            default: begin
                req_ready = 1'b0;
                rsp_valid = 1'b0;
            end
        endcase
        accept = req_ready && req_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= req_write ? '0 : rd_word;
        end
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned CNT_W       = 56,
    parameter logic [31:0] FREQ_WORD   = 32'd50_000_000,
    parameter logic [63:0] VIRT_OFFSET = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq_phys,
    output logic              irq_virt
);

    localparam int unsigned NCH  = tfr_pkg::NUM_CH;
    localparam int unsigned VW   = tfr_pkg::VAL_W;
    localparam int unsigned DW   = tfr_pkg::DATA_W;

    logic [31:0]      word_idx;
    logic             aligned;
    logic             accept;
    logic [DW-1:0]    rd_word;
    logic [CNT_W-1:0] phys_cnt;
    logic [CNT_W-1:0] virt_cnt;
    logic [VW-1:0]    phys_cnt64;
    logic [VW-1:0]    virt_cnt64;

    logic [CNT_W-1:0] ch_cnt  [NCH];
    logic [VW-1:0]    ch_cmp  [NCH];
    logic             ch_en   [NCH];
    logic             ch_mask [NCH];
    logic             ch_stat [NCH];
    logic             ch_irq  [NCH];

    assign word_idx = 32'(req_addr[ADDR_W-1:2]);
    assign aligned  = (req_addr[1:0] == 2'b00);

    tfr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (phys_cnt)
    );

    assign virt_cnt   = phys_cnt + VIRT_OFFSET[CNT_W-1:0];
    assign phys_cnt64 = VW'(phys_cnt);
    assign virt_cnt64 = VW'(virt_cnt);
    assign ch_cnt[0]  = phys_cnt;
    assign ch_cnt[1]  = virt_cnt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned BASE = tfr_pkg::ch_base(c);
        logic wr_lo, wr_hi, wr_ctl;

        assign wr_lo  = accept && req_write && aligned && (word_idx == BASE + tfr_pkg::CH_OFS_CMP_LO);
        assign wr_hi  = accept && req_write && aligned && (word_idx == BASE + tfr_pkg::CH_OFS_CMP_HI);
        assign wr_ctl = accept && req_write && aligned && (word_idx == BASE + tfr_pkg::CH_OFS_CTRL);

        tfr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (ch_cnt[c]),
            .wr_cmp_lo (wr_lo),
            .wr_cmp_hi (wr_hi),
            .wr_ctrl   (wr_ctl),
            .wdata     (req_wdata),
            .cmp_val   (ch_cmp[c]),
            .en        (ch_en[c]),
            .mask      (ch_mask[c]),
            .status    (ch_stat[c]),
            .irq       (ch_irq[c])
        );
    end

    // read multiplexer: live values at the accept edge
    always_comb begin
        rd_word = '0;
        if (aligned) begin
            case (word_idx)
                tfr_pkg::W_PCNT_LO: rd_word = phys_cnt64[DW-1:0];
                tfr_pkg::W_PCNT_HI: rd_word = phys_cnt64[VW-1:DW];
                tfr_pkg::W_VCNT_LO: rd_word = virt_cnt64[DW-1:0];
                tfr_pkg::W_VCNT_HI: rd_word = virt_cnt64[VW-1:DW];
                tfr_pkg::W_FREQ:    rd_word = FREQ_WORD;
                default: begin
                    for (int unsigned c = 0; c < NCH; c++) begin
                        if (word_idx == tfr_pkg::ch_base(c) + tfr_pkg::CH_OFS_CMP_LO) begin
                            rd_word = ch_cmp[c][DW-1:0];
                        end
                        if (word_idx == tfr_pkg::ch_base(c) + tfr_pkg::CH_OFS_CMP_HI) begin
                            rd_word = ch_cmp[c][VW-1:DW];
                        end
                        if (word_idx == tfr_pkg::ch_base(c) + tfr_pkg::CH_OFS_CTRL) begin
                            rd_word[tfr_pkg::CTRL_EN]   = ch_en[c];
                            rd_word[tfr_pkg::CTRL_MASK] = ch_mask[c];
                            rd_word[tfr_pkg::CTRL_STAT] = ch_stat[c];
                        end
                    end
                end
            endcase
        end
    end

    tfr_bus_fsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_word   (rd_word),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign irq_phys = ch_irq[0];
    assign irq_virt = ch_irq[1];

endmodule

// File: rtl/tfr_frame_chk.sv
module tfr_frame_chk #(
    parameter int unsigned CNT_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             irq_phys,
    input logic             irq_virt,
    input logic [CNT_W-1:0] phys_cnt,
    input logic             phys_en,
    input logic             phys_mask,
    input logic             virt_en,
    input logic             virt_mask
);

    assert_rsp_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (phys_cnt == $past(phys_cnt) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(phys_cnt));

    assert_phys_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_phys |-> (phys_en && !phys_mask));

    assert_virt_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_virt |-> (virt_en && !virt_mask));

endmodule

bind cmp_timer_frame tfr_frame_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .irq_phys  (irq_phys),
    .irq_virt  (irq_virt),
    .phys_cnt  (phys_cnt),
    .phys_en   (ch_en[0]),
    .phys_mask (ch_mask[0]),
    .virt_en   (ch_en[1]),
    .virt_mask (ch_mask[1])
);

// File: tb/cmp_timer_frame_tb_top.sv
module cmp_timer_frame_tb_top;

    localparam logic [31:0] FREQ   = 32'h0124_F800;
    localparam logic [63:0] OFFS   = 64'h00FF_FFFF_FFFF_FFF8;
    localparam logic [63:0] MASK56 = 64'h00FF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_phys;
    logic        irq_virt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmp_timer_frame #(
        .ADDR_W(8), .CNT_W(56), .FREQ_WORD(FREQ), .VIRT_OFFSET(OFFS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_phys(irq_phys), .irq_virt(irq_virt)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [63:0] m_cnt;
    logic [63:0] m_cmp [2];
    logic        m_en [2];
    logic        m_mask [2];
    logic        m_busy, m_rsp_v, m_live;
    logic [31:0] m_rdata;
    string       m_tag;

    initial m_live = 1'b0;

    function automatic logic [63:0] m_count(int ch);
        return (ch == 0) ? m_cnt : ((m_cnt + OFFS) & MASK56);
    endfunction

    function automatic logic m_stat(int ch);
        return m_en[ch] && (m_count(ch) >= m_cmp[ch]);
    endfunction

    function automatic string tag_of(logic [7:0] a);
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return "R10";
        if (w <= 3) return "R3";
        if (w == 4) return "R4";
        if (w == 8 || w == 9 || w == 12 || w == 13) return "R5";
        if (w == 11 || w == 15) return "R6";
        return "R10";
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int w = int'(a[7:2]);
        logic [63:0] v;
        if (a[1:0] != 2'b00) return 32'h0;
        case (w)
            0: begin v = m_count(0); return v[31:0]; end
            1: begin v = m_count(0); return v[63:32]; end
            2: begin v = m_count(1); return v[31:0]; end
            3: begin v = m_count(1); return v[63:32]; end
            4: return FREQ;
            8: return m_cmp[0][31:0];
            9: return m_cmp[0][63:32];
            11: return {29'h0, m_stat(0), m_mask[0], m_en[0]};
            12: return m_cmp[1][31:0];
            13: return m_cmp[1][63:32];
            15: return {29'h0, m_stat(1), m_mask[1], m_en[1]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_write(logic [7:0] a, logic [31:0] d);
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return;
        case (w)
            8:  m_cmp[0][31:0]  = d;
            9:  m_cmp[0][63:32] = d;
            11: begin m_en[0] = d[0]; m_mask[0] = d[1]; end
            12: m_cmp[1][31:0]  = d;
            13: m_cmp[1][63:32] = d;
            15: begin m_en[1] = d[0]; m_mask[1] = d[1]; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0;
            for (int c = 0; c < 2; c++) begin
                m_cmp[c] = '0; m_en[c] = 1'b0; m_mask[c] = 1'b0;
            end
            m_busy = 1'b0; m_rsp_v = 1'b0; m_rdata = '0; m_tag = "R9";
            m_live = 1'b1;
        end else begin
            if (m_busy) begin
                m_busy = 1'b0; m_rsp_v = 1'b0;
            end else if (req_valid) begin
                m_rdata = req_write ? 32'h0 : m_read(req_addr);
                m_tag   = req_write ? "R9" : tag_of(req_addr);
                if (req_write) m_write(req_addr, req_wdata);
                m_busy = 1'b1; m_rsp_v = 1'b1;
            end
            if (tick_en) m_cnt = (m_cnt + 64'd1) & MASK56;
        end
    end

    // per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk(req_ready === !m_busy, "R9", "req_ready", 64'(req_ready), 64'(!m_busy));
            chk(rsp_valid === m_rsp_v, "R9", "rsp_valid", 64'(rsp_valid), 64'(m_rsp_v));
            if (m_rsp_v)
                chk(rsp_rdata === m_rdata, m_tag, "rsp_rdata", 64'(rsp_rdata), 64'(m_rdata));
            chk(irq_phys === (m_stat(0) && !m_mask[0]), "R8", "irq_phys model",
                64'(irq_phys), 64'(m_stat(0) && !m_mask[0]));
            chk(irq_virt === (m_stat(1) && !m_mask[1]), "R8", "irq_virt model",
                64'(irq_virt), 64'(m_stat(1) && !m_mask[1]));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        q = rsp_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] q;
        xfer(1'b0, a, 32'h0, q);
        chk(q === exp, tag, $sformatf("read 0x%02h", a), 64'(q), 64'(exp));
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] q1, q2;
        logic [7:0]  addrs [12];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h24, 8'h2C,
                  8'h30, 8'h34, 8'h3C, 8'h18};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(req_ready === 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(irq_phys === 1'b0 && irq_virt === 1'b0, "R1", "irqs after reset",
            64'({irq_phys, irq_virt}), 64'd0);
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h2C, 32'h0, "R1");
        rd_chk(8'h3C, 32'h0, "R1");
        rd_chk(8'h24, 32'h0, "R1");

        // R3 virtual view before ticks: 0 + offset, upper byte zero (R2)
        rd_chk(8'h08, 32'hFFFF_FFF8, "R3");
        rd_chk(8'h0C, 32'h00FF_FFFF, "R2");

        // R4 frequency, write ignored
        rd_chk(8'h10, FREQ, "R4");
        wr(8'h10, 32'hDEAD_BEEF);
        rd_chk(8'h10, FREQ, "R4");

        // R2 ten ticks; R3 virtual wraps to 2
        ticks(10);
        rd_chk(8'h00, 32'd10, "R2");
        rd_chk(8'h04, 32'd0, "R2");
        rd_chk(8'h08, 32'd2, "R3");
        rd_chk(8'h0C, 32'd0, "R3");
        wr(8'h00, 32'h1234);
        rd_chk(8'h00, 32'd10, "R3");

        // R10 unmapped and misaligned
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk(8'h18, 32'h0, "R10");
        rd_chk(8'h40, 32'h0, "R10");
        wr(8'h21, 32'h5555_5555);
        rd_chk(8'h20, 32'h0, "R10");
        rd_chk(8'h22, 32'h0, "R10");

        // R5 compare halves
        wr(8'h20, 32'h0000_0005);
        wr(8'h24, 32'h0000_0001);
        rd_chk(8'h20, 32'h0000_0005, "R5");
        rd_chk(8'h24, 32'h0000_0001, "R5");
        wr(8'h34, 32'hABCD_0000);
        rd_chk(8'h34, 32'hABCD_0000, "R5");
        rd_chk(8'h30, 32'h0, "R5");
        wr(8'h34, 32'h0);

        // R6 status write ignored, upper bits zero; R7 high word decides
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_chk(8'h2C, 32'h3, "R6");
        wr(8'h3C, 32'hFFFF_FFFC);
        rd_chk(8'h3C, 32'h0, "R6");
        wr(8'h24, 32'h0);
        rd_chk(8'h2C, 32'h7, "R7");
        chk(irq_phys === 1'b0, "R8", "masked irq low", 64'(irq_phys), 64'd0);
        wr(8'h2C, 32'h1);
        chk(irq_phys === 1'b1, "R8", "unmasked irq high", 64'(irq_phys), 64'd1);
        rd_chk(8'h2C, 32'h5, "R8");
        wr(8'h2C, 32'h3);
        chk(irq_phys === 1'b0, "R8", "mask silences irq", 64'(irq_phys), 64'd0);
        rd_chk(8'h2C, 32'h7, "R8");
        wr(8'h2C, 32'h0);
        rd_chk(8'h2C, 32'h0, "R7");

        // R7 virtual channel reaching its compare
        wr(8'h30, 32'd5);
        wr(8'h3C, 32'h1);
        chk(irq_virt === 1'b0, "R7", "virt below compare", 64'(irq_virt), 64'd0);
        rd_chk(8'h3C, 32'h1, "R7");
        ticks(3);
        chk(irq_virt === 1'b1, "R7", "virt at compare", 64'(irq_virt), 64'd1);
        rd_chk(8'h3C, 32'h5, "R7");
        rd_chk(8'h00, 32'd13, "R2");

        // R3 live reads while counting
        @(negedge clk);
        tick_en = 1'b1;
        xfer(1'b0, 8'h00, 32'h0, q1);
        xfer(1'b0, 8'h00, 32'h0, q2);
        tick_en = 1'b0;
        chk(q2 != q1, "R3", "live count differs", 64'(q2), 64'(q1));

        // mixed traffic, model compared every clock
        for (int i = 0; i < 400; i++) begin
            logic [31:0] q;
            logic [7:0]  a = addrs[$urandom_range(0, 11)];
            bit          w = ($urandom_range(0, 2) == 0);
            logic [31:0] d = $urandom;
            if (a == 8'h24 || a == 8'h34) d = d & 32'h0;
            if (a == 8'h20 || a == 8'h30) d = d & 32'h0000_03FF;
            tick_en = ($urandom_range(0, 1) == 1);
            xfer(w, a, d, q);
        end
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule